// File: doc/BRIEF.md
# Lookup-Table Logic Cell with Function Cascade and Writable Tables

This block is one tile of a reconfigurable logic fabric. Two 4-input lookup tables, here called the F table and the G table, each hold 16 bits and return the bit that their own four select inputs address. A third, 8-bit table, called the H table, is addressed by the F result, the G result and one extra input. The H table can act as a 2:1 selector between F and G, which makes any function of five inputs. It can also be any other 3-input function of its three signals.

Each of the two outputs, X and Y, chooses its source by configuration. X takes F or H, and Y takes G or H. Each output is then either passed straight through or captured in a flip-flop. The flip-flops have a clock enable and a synchronous set/reset line. The active level of that line and the value each flip-flop takes on set/reset are configuration bits. A configuration bit can also turn the two 16-bit tables into a 16-word by 2-bit RAM. This RAM is written at the address on the F inputs and read through the normal lookup path.

All configuration is loaded serially, one bit per clock, through a shift chain. While loading is in progress, the flip-flops are held at zero.

Top module: `clb_tile`

## Requirements
- R1: With the X output set to direct and to the F source, `x_out` equals bit `f_in` of the F table, in the same cycle.
- R2: With the Y output set to direct and to the G source, `y_out` equals bit `g_in` of the G table, in the same cycle.
- R3: The H result is bit `{h_in, G result, F result}` of the H table: `h_in` is the index MSB and the F result is the LSB. X shows it when its source bit selects H.
- R4: With F and G addressed by the same four inputs and the H table set to 8'hCA, X in direct mode gives bit `{h_in, f_in}` of the 32-bit function whose low half is the F table and whose high half is the G table.
- R5: When an output's register bit is set, it shows its flip-flop. On a rising edge with set/reset inactive, the flip-flop takes the selected source if `ce` is high and keeps its value if `ce` is low.
- R6: When set/reset is active at a rising edge, the flip-flop takes its configured set/reset value, whatever `ce` is. Set/reset is active when `sr` is high if the polarity bit is 1, and when `sr` is low if the polarity bit is 0.
- R7: `cfg_din` is taken on every rising edge while `cfg_shift` is high. After 48 such edges, the bit shifted first is configuration bit 0 and the bit shifted last is bit 47.
- R8: Configuration bits 0–15 are the F table (bit i = entry i), 16–31 the G table, and 32–39 the H table. The option bits are: 40 X source (1 = H), 41 Y source (1 = H), 42 X registered, 43 Y registered, 44 X set/reset value, 45 Y set/reset value, 46 set/reset polarity (1 = active high), 47 RAM mode.
- R9: Reset (`rst_n` low) clears every configuration bit and both flip-flops. Any edge with `cfg_shift` high leaves both flip-flops at 0.
- R10: In RAM mode, a rising edge with `ram_we` high and `cfg_shift` low writes `ram_wd[0]` into F entry `f_in` and `ram_wd[1]` into G entry `f_in`. The new bits show on the lookup outputs only after that edge.
- R11: With the RAM mode bit clear, `ram_we` does not change either table.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flip-flops, the configuration chain and RAM writes |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_shift | input | 1 | Shifts configuration data in while high |
| cfg_din | input | 1 | Serial configuration bit |
| f_in | input | LUT_K | F table select; also the RAM write address |
| g_in | input | LUT_K | G table select |
| h_in | input | 1 | Extra H table select (index MSB) |
| ce | input | 1 | Flip-flop clock enable |
| sr | input | 1 | Set/reset line, active level chosen by configuration |
| ram_we | input | 1 | RAM write enable (used in RAM mode only) |
| ram_wd | input | 2 | RAM write data: bit 0 goes to F, bit 1 goes to G |
| x_out | output | 1 | X output (F or H, direct or registered) |
| y_out | output | 1 | Y output (G or H, direct or registered) |

## Verification
The bench builds the tile with its defaults: LUT_K = 4, which gives a 48-bit chain, and READ_STYLE = 1, which selects the generated binary mux-tree read path. These values let the bench sweep all 32 entries of the five-input cascade and all eight H indices. They also keep a full reload short enough to repeat for every option set, including both set/reset polarities. Because the F and G tables are only 16 deep, RAM writes can land at chosen addresses. The bench can then confirm that the G half is written at the F address rather than at the G address.

// File: rtl/clb_pkg.sv
package clb_pkg;

   localparam int H_SEL_W = 3;
   localparam int H_BITS  = 1 << H_SEL_W;

   // option field, LSB first: sel_x is configuration bit right after the H table
   typedef struct packed {
      logic ram_mode;
      logic sr_pol;
      logic srv_y;
      logic srv_x;
      logic reg_y;
      logic reg_x;
      logic sel_y;
      logic sel_x;
   } clb_opt_t;

   localparam int OPT_W = $bits(clb_opt_t);

   typedef enum logic {
      SRC_LUT = 1'b0,
      SRC_H   = 1'b1
   } clb_src_e;

endpackage

// File: rtl/clb_cfg_store.sv
module clb_cfg_store
   import clb_pkg::*;
#(
   parameter int LUT_K = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    shift_en,
   input  logic                    shift_din,
   input  logic                    ram_we,
   input  logic [LUT_K-1:0]        ram_addr,
   input  logic [1:0]              ram_wd,
   output logic [(1<<LUT_K)-1:0]   f_tab,
   output logic [(1<<LUT_K)-1:0]   g_tab,
   output logic [H_BITS-1:0]       h_tab,
   output clb_opt_t                opt
);

   localparam int DEPTH = 1 << LUT_K;
   localparam int G_LO  = DEPTH;
   localparam int H_LO  = 2 * DEPTH;
   localparam int O_LO  = H_LO + H_BITS;
   localparam int CFG_W = O_LO + OPT_W;

   logic [CFG_W-1:0] cfg_q;
   logic [CFG_W-1:0] cfg_d;
   logic             wr_go;

   assign f_tab = cfg_q[0 +: DEPTH];
   assign g_tab = cfg_q[G_LO +: DEPTH];
   assign h_tab = cfg_q[H_LO +: H_BITS];
   assign opt   = clb_opt_t'(cfg_q[O_LO +: OPT_W]);

   // loading wins over memory writes
   assign wr_go = ram_we & opt.ram_mode & ~shift_en;

   always_comb begin
      cfg_d = cfg_q;
      if (shift_en) begin
         cfg_d = {shift_din, cfg_q[CFG_W-1:1]};
      end else if (wr_go) begin
         for (int i = 0; i < DEPTH; i++) begin
            if (ram_addr == LUT_K'(i)) begin
               cfg_d[i]        = ram_wd[0];
               cfg_d[G_LO + i] = ram_wd[1];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q <= '0;
      else        cfg_q <= cfg_d;
   end

endmodule

// File: rtl/clb_lut.sv
module clb_lut #(
   parameter int K          = 4,
   parameter int READ_STYLE = 1
) (
   input  logic [(1<<K)-1:0] tab,
   input  logic [K-1:0]      sel,
   output logic              y
);

   localparam int DEPTH = 1 << K;

   if (K < 1 || K > 6) begin : g_bad_k
      $error("clb_lut: K must lie in 1..6");
   end

   if (READ_STYLE == 0) begin : g_index
      assign y = tab[sel];
   end else if (READ_STYLE == 1) begin : g_tree
      // heap-ordered tree: node 1 is the root, leaves sit at DEPTH..2*DEPTH-1
      logic node [1:2*DEPTH-1];
      for (genvar i = 0; i < DEPTH; i++) begin : g_leaf
         assign node[DEPTH + i] = tab[i];
      end
      for (genvar d = 0; d < K; d++) begin : g_lvl
         for (genvar j = 0; j < (1 << d); j++) begin : g_node
            localparam int N = (1 << d) + j;
            assign node[N] = sel[K-1-d] ? node[2*N + 1] : node[2*N];
         end
      end
      assign y = node[1];
   end else begin : g_bad_style
      $error("clb_lut: READ_STYLE must be 0 or 1");
   end

endmodule

// File: rtl/clb_out_stage.sv
module clb_out_stage
   import clb_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     hold_clr,
   input  logic     lut_v,
   input  logic     h_v,
   input  clb_src_e src_sel,
   input  logic     ce,
   input  logic     sr_act,
   input  logic     sr_val,
   input  logic     reg_sel,
   output logic     src_v,
   output logic     q,
   output logic     o
);

   assign src_v = (src_sel == SRC_H) ? h_v : lut_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= 1'b0;
      else if (hold_clr) q <= 1'b0;
      else if (sr_act)   q <= sr_val;
      else if (ce)       q <= src_v;
   end

   assign o = reg_sel ? q : src_v;

endmodule

// File: rtl/clb_tile.sv
module clb_tile
   import clb_pkg::*;
#(
   parameter int LUT_K      = 4,
   parameter int READ_STYLE = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_shift,
   input  logic             cfg_din,
   input  logic [LUT_K-1:0] f_in,
   input  logic [LUT_K-1:0] g_in,
   input  logic             h_in,
   input  logic             ce,
   input  logic             sr,
   input  logic             ram_we,
   input  logic [1:0]       ram_wd,
   output logic             x_out,
   output logic             y_out
);

   localparam int DEPTH = 1 << LUT_K;
   localparam int LANES = 2;

   if (LUT_K < 2 || LUT_K > 6) begin : g_bad_k
      $error("clb_tile: LUT_K must lie in 2..6");
   end

   logic [DEPTH-1:0]  f_tab;
   logic [DEPTH-1:0]  g_tab;
   logic [H_BITS-1:0] h_tab;
   clb_opt_t          opt;
   logic              f_val;
   logic              g_val;
   logic              h_val;
   logic              sr_act;

   clb_cfg_store #(.LUT_K(LUT_K)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (cfg_shift),
      .shift_din(cfg_din),
      .ram_we   (ram_we),
      .ram_addr (f_in),
      .ram_wd   (ram_wd),
      .f_tab    (f_tab),
      .g_tab    (g_tab),
      .h_tab    (h_tab),
      .opt      (opt)
   );

   clb_lut #(.K(LUT_K), .READ_STYLE(READ_STYLE)) u_f (
      .tab(f_tab), .sel(f_in), .y(f_val)
   );

   clb_lut #(.K(LUT_K), .READ_STYLE(READ_STYLE)) u_g (
      .tab(g_tab), .sel(g_in), .y(g_val)
   );

   clb_lut #(.K(H_SEL_W), .READ_STYLE(READ_STYLE)) u_h (
      .tab(h_tab), .sel({h_in, g_val, f_val}), .y(h_val)
   );

   assign sr_act = opt.sr_pol ? sr : ~sr;

   logic [LANES-1:0] lane_lut;
   logic [LANES-1:0] lane_sel;
   logic [LANES-1:0] lane_reg;
   logic [LANES-1:0] lane_srv;
   logic [LANES-1:0] lane_src;
   logic [LANES-1:0] lane_q;
   logic [LANES-1:0] lane_o;

   assign lane_lut = {g_val, f_val};
   assign lane_sel = {opt.sel_y, opt.sel_x};
   assign lane_reg = {opt.reg_y, opt.reg_x};
   assign lane_srv = {opt.srv_y, opt.srv_x};

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      clb_out_stage u_out (
         .clk     (clk),
         .rst_n   (rst_n),
         .hold_clr(cfg_shift),
         .lut_v   (lane_lut[i]),
         .h_v     (h_val),
         .src_sel (clb_src_e'(lane_sel[i])),
         .ce      (ce),
         .sr_act  (sr_act),
         .sr_val  (lane_srv[i]),
         .reg_sel (lane_reg[i]),
         .src_v   (lane_src[i]),
         .q       (lane_q[i]),
         .o       (lane_o[i])
      );
   end

   assign x_out = lane_o[0];
   assign y_out = lane_o[1];

endmodule

// File: rtl/clb_tile_chk.sv
module clb_tile_chk #(
   parameter int DEPTH = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cfg_shift,
   input logic               ce,
   input logic               sr,
   input logic               x_out,
   input logic               y_out,
   input logic [1:0]         ff_q,
   input logic [1:0]         src_v,
   input logic               ram_mode,
   input logic               sr_pol,
   input logic [1:0]         srv,
   input logic [1:0]         reg_sel,
   input logic [2*DEPTH-1:0] lut_bits
);

   p_load_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_shift |=> (ff_q == 2'b00));

   p_ram_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_shift && !ram_mode) |=> $stable(lut_bits));

   p_xreg_r5: assert property (@(posedge clk) disable iff (!rst_n)
      reg_sel[0] |-> (x_out == ff_q[0]));

   p_yreg_r5: assert property (@(posedge clk) disable iff (!rst_n)
      reg_sel[1] |-> (y_out == ff_q[1]));

   p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_shift && ce && (sr_pol ? !sr : sr)) |=> (ff_q == $past(src_v)));

   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_shift && !ce && (sr_pol ? !sr : sr)) |=> $stable(ff_q));

   p_setreset_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_shift && (sr_pol ? sr : !sr)) |=> (ff_q == $past(srv)));

   p_xdirect_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_sel[0] |-> (x_out == src_v[0]));

endmodule

bind clb_tile clb_tile_chk #(.DEPTH(DEPTH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cfg_shift(cfg_shift),
   .ce       (ce),
   .sr       (sr),
   .x_out    (x_out),
   .y_out    (y_out),
   .ff_q     (lane_q),
   .src_v    (lane_src),
   .ram_mode (opt.ram_mode),
   .sr_pol   (opt.sr_pol),
   .srv      (lane_srv),
   .reg_sel  (lane_reg),
   .lut_bits ({g_tab, f_tab})
);

// File: tb/tb_clb_tile.sv
module tb_clb_tile;

   localparam int CLK_P = 10;
   localparam int CFG_W = 48;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       cfg_shift;
   logic       cfg_din;
   logic [3:0] f_in;
   logic [3:0] g_in;
   logic       h_in;
   logic       ce;
   logic       sr;
   logic       ram_we;
   logic [1:0] ram_wd;
   logic       x_out;
   logic       y_out;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   string      tag_q[$];
   logic [1:0] exp_q[$];
   event       chk_ev;

   always #(CLK_P/2) clk = ~clk;

   clb_tile dut (
      .clk(clk), .rst_n(rst_n), .cfg_shift(cfg_shift), .cfg_din(cfg_din),
      .f_in(f_in), .g_in(g_in), .h_in(h_in), .ce(ce), .sr(sr),
      .ram_we(ram_we), .ram_wd(ram_wd), .x_out(x_out), .y_out(y_out)
   );

   // monitor: pops expected {y,x} pairs and compares against the pins
   initial begin
      forever begin
         @(chk_ev);
         while (exp_q.size() > 0) begin
            string      t;
            logic [1:0] e;
            t = tag_q.pop_front();
            e = exp_q.pop_front();
            n_run++;
            if ({y_out, x_out} !== e) begin
               n_fail++;
               $display("FAIL %s: {y,x} actual=%b expected=%b", t, {y_out, x_out}, e);
            end
         end
      end
   end

   task automatic expect_yx(input string t, input logic [1:0] e);
      #1;
      tag_q.push_back(t);
      exp_q.push_back(e);
      ->chk_ev;
      #1;
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic [CFG_W-1:0] mk(input logic [15:0] f, input logic [15:0] g,
                                           input logic [7:0] h, input logic [7:0] o);
      return {o, h, g, f};
   endfunction

   task automatic load_cfg(input logic [CFG_W-1:0] v);
      for (int k = 0; k < CFG_W; k++) begin
         @(negedge clk);
         cfg_shift = 1'b1;
         cfg_din   = v[k];
      end
      @(negedge clk);
      cfg_shift = 1'b0;
      cfg_din   = 1'b0;
   endtask

   localparam logic [15:0] T_F = 16'hA5C3;
   localparam logic [15:0] T_G = 16'h0FF0;
   localparam logic [7:0]  T_H = 8'h96;
   localparam logic [31:0] T5  = 32'hDEAD_BEEF;

   initial begin
      rst_n = 1'b0; cfg_shift = 1'b0; cfg_din = 1'b0;
      f_in = '0; g_in = '0; h_in = 1'b0; ce = 1'b0; sr = 1'b0;
      ram_we = 1'b0; ram_wd = '0;
      repeat (3) @(negedge clk);
      expect_yx("R9 reset", 2'b00);
      rst_n = 1'b1;

      // R1 R2 R7 R8: plain lookups after serial load
      load_cfg(mk(T_F, T_G, 8'h00, 8'h00));
      f_in = 4'd0;  g_in = 4'd0;  expect_yx("R7 first shifted bit", {T_G[0], T_F[0]});
      f_in = 4'd15; g_in = 4'd15; expect_yx("R8 table ends", {T_G[15], T_F[15]});
      for (int i = 0; i < 6; i++) begin
         f_in = 4'(i*5 + 1);
         g_in = 4'(i*3 + 2);
         expect_yx("R1 R2 lookup", {T_G[g_in], T_F[f_in]});
      end

      // R3: H index {h_in, G, F}; F=1 at 0, F=0 at 2; G=0 at 0, G=1 at 4
      load_cfg(mk(T_F, T_G, T_H, 8'h01));
      for (int idx = 0; idx < 8; idx++) begin
         f_in = (idx % 2 == 1) ? 4'd0 : 4'd2;
         g_in = ((idx / 2) % 2 == 1) ? 4'd4 : 4'd0;
         h_in = (idx >= 4);
         expect_yx("R3 H lookup", {1'((idx / 2) % 2), T_H[idx]});
      end
      h_in = 1'b0;

      // R4: five-input function through the cascade
      load_cfg(mk(T5[15:0], T5[31:16], 8'hCA, 8'h01));
      for (int v = 0; v < 32; v++) begin
         f_in = 4'(v);
         g_in = 4'(v);
         h_in = (v >= 16);
         expect_yx("R4 five-input", {T5[16 + (v % 16)], T5[v]});
      end
      h_in = 1'b0;

      // R5: registered outputs, active-high set/reset inactive
      load_cfg(mk(T_F, T_G, 8'h00, 8'h4C));
      expect_yx("R9 flops clear after load", 2'b00);
      ce = 1'b1; f_in = 4'd0; g_in = 4'd4;
      expect_yx("R5 no change before edge", 2'b00);
      tick();
      expect_yx("R5 capture with ce", 2'b11);
      ce = 1'b0; f_in = 4'd2; g_in = 4'd0;
      tick();
      expect_yx("R5 hold without ce", 2'b11);
      ce = 1'b1;
      tick();
      expect_yx("R5 capture again", 2'b00);

      // R6: active-high set/reset, x value 1, y value 0, priority over ce
      load_cfg(mk(T_F, T_G, 8'h00, 8'h5C));
      ce = 1'b1; f_in = 4'd0; g_in = 4'd4;
      tick();
      expect_yx("R6 setup capture", 2'b11);
      sr = 1'b1;
      tick();
      expect_yx("R6 set/reset over ce", 2'b01);
      sr = 1'b0;
      tick();
      expect_yx("R6 release", 2'b11);

      // R6: active-low set/reset
      sr = 1'b1;
      load_cfg(mk(T_F, T_G, 8'h00, 8'h1C));
      ce = 1'b1; f_in = 4'd2; g_in = 4'd4;
      tick();
      expect_yx("R6 low polarity inactive", 2'b10);
      sr = 1'b0;
      tick();
      expect_yx("R6 low polarity active", 2'b01);
      sr = 1'b1; ce = 1'b0;

      // R10: RAM mode writes at the F address
      load_cfg(mk(16'h0000, 16'h0000, 8'h00, 8'h80));
      f_in = 4'd5; g_in = 4'd5; ram_wd = 2'b11; ram_we = 1'b1;
      expect_yx("R10 not visible before edge", 2'b00);
      tick();
      ram_we = 1'b0;
      expect_yx("R10 visible after edge", 2'b11);
      f_in = 4'd9; ram_wd = 2'b01; ram_we = 1'b1;
      tick();
      ram_we = 1'b0; g_in = 4'd9;
      expect_yx("R10 second word", 2'b01);
      f_in = 4'd5; g_in = 4'd5;
      expect_yx("R10 first word kept", 2'b11);
      f_in = 4'd3; g_in = 4'd7; ram_wd = 2'b10; ram_we = 1'b1;
      tick();
      ram_we = 1'b0;
      expect_yx("R10 G not written at g_in", 2'b00);
      g_in = 4'd3;
      expect_yx("R10 G written at f_in", 2'b10);

      // R11: writes ignored outside RAM mode
      load_cfg(mk(T_F, T_G, 8'h00, 8'h00));
      f_in = 4'd2; g_in = 4'd2; ram_wd = 2'b11; ram_we = 1'b1;
      tick();
      ram_we = 1'b0;
      expect_yx("R11 tables unchanged", {T_G[2], T_F[2]});

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule